// File: doc/BRIEF.md
# Hardwired Instruction Control Decoder

This block is the decode front end of a hardwired controller for a small 16-bit accumulator machine. It captures a fetched instruction word and splits it into three parts. The top bit goes to a separate indirect flag. The next three bits form an operation code, which is decoded into eight one-hot operation lines. The low twelve bits are passed on undecoded as an address or operation selector.

A 4-bit step counter drives a second decoder, which produces sixteen one-hot timing lines. Downstream register-transfer logic combines the operation lines, the timing lines, the indirect flag and the low instruction bits into its micro-operations. That logic also steers the step counter through clear, load and increment inputs.

The block also forms a minimal fetch, decode and indirect sequence. The instruction register captures only during the fetch slot. Three qualified flags mark the following cases:
- a memory-reference instruction that needs an indirect address step;
- a register-reference instruction;
- an input/output instruction.

Top module: `hw_ctrl_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, the step counter, the instruction register and the indirect flag are cleared. After that edge `t_lines` is 16'h0001, `d_lines` is 8'h01, `ind_flag` is 0 and `addr_bits` is 0.
- R2: `t_lines` is always one-hot, with bit n set when the step counter holds n.
- R3: With `sc_inc` high and neither `sc_clr` nor `sc_load` high, the step counter advances by one per edge, and after 15 it wraps to 0.
- R4: `sc_clr` has the highest priority. After an edge with `sc_clr` high, `t_lines` is 16'h0001, whatever `sc_load` and `sc_inc` are.
- R5: With `sc_load` high and `sc_clr` low, the step counter takes `sc_load_val` at the edge, even when `sc_inc` is also high.
- R6: With `sc_clr`, `sc_load` and `sc_inc` all low, the step counter holds its value.
- R7: The instruction register and the indirect flag capture `mem_word` only at an edge where `ir_load` is high and the step counter is 1 (the fetch slot). A load request in any other step has no effect. The capture uses the step value from before that edge's counter update.
- R8: `d_lines` is one-hot, with bit k set when instruction bits 14:12 equal k.
- R9: `ind_flag` equals bit 15 of the last captured word. `addr_bits` equals bits 11:0 of that word.
- R10: `reg_ref` is high exactly when bit 7 of `d_lines` is high and `ind_flag` is 0. `io_ref` is high exactly when bit 7 of `d_lines` is high and `ind_flag` is 1.
- R11: `ind_step` is high exactly when the step counter is 3, `ind_flag` is 1 and bit 7 of `d_lines` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_word | input | 16 | Instruction word from memory |
| ir_load | input | 1 | Instruction register load request |
| sc_clr | input | 1 | Step counter clear |
| sc_load | input | 1 | Step counter parallel load |
| sc_load_val | input | 4 | Value loaded into the step counter |
| sc_inc | input | 1 | Step counter increment |
| t_lines | output | 16 | One-hot timing lines |
| d_lines | output | 8 | One-hot operation lines |
| ind_flag | output | 1 | Captured indirect bit |
| addr_bits | output | 12 | Undecoded low instruction bits |
| reg_ref | output | 1 | Register-reference instruction present |
| io_ref | output | 1 | Input/output instruction present |
| ind_step | output | 1 | Indirect address step is due now |

## Verification
Two pairs of functions can act in the same cycle, and both are provoked on purpose.

The first pair is the step counter's controls. The bench raises clear together with load and increment, and it raises load together with increment. It then judges the next timing line against the stated priority.

The second pair is an instruction capture at the fetch slot and the counter advance at that same edge. The bench loads a word while incrementing out of step 1, and checks that the capture happened and that the following step is 2. It then repeats the load request in other steps and checks that the captured fields stay unchanged.

// File: rtl/hwc_pkg.sv
// Package: shared widths for the hardwired control decoder.
// Assumes a fixed split of the instruction word: indirect bit, operation code, address field.
package hwc_pkg;
    parameter int INSTR_W = 16;
    parameter int OPC_W   = 3;
    parameter int ADDR_W  = 12;
    parameter int SC_W    = 4;
    localparam int NUM_OPS = 1 << OPC_W;
    localparam int NUM_T   = 1 << SC_W;
endpackage

// File: rtl/hwc_onehot_dec.sv
// Module: binary to one-hot decoder, used for both the opcode and the step counter.
// Assumes the output width is 2**IN_W. The output is purely combinational.
module hwc_onehot_dec #(
    parameter int IN_W  = 3,
    localparam int OUT_W = 1 << IN_W
) (
    input  logic [IN_W-1:0]  code,
    output logic [OUT_W-1:0] lines
);
    // Generate one comparator per output line.
    for (genvar g = 0; g < OUT_W; g++) begin : g_line
        assign lines[g] = (code == IN_W'(g));
    end
endmodule

// File: rtl/hwc_seq_counter.sv
// Module: step counter with clear, load and increment controls.
// Assumes priority clear > load > increment > hold, and wraps at the top value.
module hwc_seq_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_nxt;

    // Select the next count by priority.
    always_comb begin
        if (clr)      cnt_nxt = '0;
        else if (ld)  cnt_nxt = ld_val;
        else if (inc) cnt_nxt = cnt + W'(1);
        else          cnt_nxt = cnt;
    end

    // Register the count, with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_nxt;
    end
endmodule

// File: rtl/hwc_instr_reg.sv
// Module: instruction register plus a separate indirect flip-flop.
// Assumes the indirect bit is the top bit of the word, the opcode sits directly below it,
// and the address field fills the low bits.
module hwc_instr_reg #(
    parameter int INSTR_W = 16,
    parameter int OPC_W   = 3,
    parameter int ADDR_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [INSTR_W-1:0] word,
    output logic               ind,
    output logic [OPC_W-1:0]   opcode,
    output logic [ADDR_W-1:0]  addr
);
    localparam int OPC_LO = ADDR_W;
    localparam int IND_B  = INSTR_W - 1;

    logic [INSTR_W-1:0] ir_q;

    // Capture the word and its indirect bit together when load is granted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= '0;
            ind  <= 1'b0;
        end else if (load) begin
            ir_q <= word;
            ind  <= word[IND_B];
        end
    end

    // Split the stored word into its opcode and address fields.
    always_comb begin
        opcode = ir_q[OPC_LO +: OPC_W];
        addr   = ir_q[ADDR_W-1:0];
    end
endmodule

// File: rtl/hw_ctrl_decoder.sv
// Module: top of the hardwired control decoder.
// Assumes the instruction register loads only in step FETCH_SLOT, and that the indirect
// address step falls in step IND_SLOT. Every output comes from registered state.
module hw_ctrl_decoder
    import hwc_pkg::*;
#(
    parameter int FETCH_SLOT = 1,
    parameter int IND_SLOT   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] mem_word,
    input  logic               ir_load,
    input  logic               sc_clr,
    input  logic               sc_load,
    input  logic [SC_W-1:0]    sc_load_val,
    input  logic               sc_inc,
    output logic [NUM_T-1:0]   t_lines,
    output logic [NUM_OPS-1:0] d_lines,
    output logic               ind_flag,
    output logic [ADDR_W-1:0]  addr_bits,
    output logic               reg_ref,
    output logic               io_ref,
    output logic               ind_step
);
    localparam int TOP_OP = NUM_OPS - 1;

    logic [SC_W-1:0]  sc_cnt;
    logic [OPC_W-1:0] opcode;
    logic             ir_grant;

    hwc_seq_counter #(.W(SC_W)) u_sc (
        .clk(clk), .rst_n(rst_n), .clr(sc_clr), .ld(sc_load),
        .ld_val(sc_load_val), .inc(sc_inc), .cnt(sc_cnt)
    );

    hwc_onehot_dec #(.IN_W(SC_W)) u_tdec (.code(sc_cnt), .lines(t_lines));

    // Grant the instruction load only in the fetch slot.
    always_comb ir_grant = ir_load && t_lines[FETCH_SLOT];

    hwc_instr_reg #(.INSTR_W(INSTR_W), .OPC_W(OPC_W), .ADDR_W(ADDR_W)) u_ir (
        .clk(clk), .rst_n(rst_n), .load(ir_grant), .word(mem_word),
        .ind(ind_flag), .opcode(opcode), .addr(addr_bits)
    );

    hwc_onehot_dec #(.IN_W(OPC_W)) u_ddec (.code(opcode), .lines(d_lines));

    // Qualify the instruction class and the indirect step.
    always_comb begin
        reg_ref  = d_lines[TOP_OP] && !ind_flag;
        io_ref   = d_lines[TOP_OP] && ind_flag;
        ind_step = t_lines[IND_SLOT] && ind_flag && !d_lines[TOP_OP];
    end
endmodule

// File: rtl/hw_ctrl_decoder_chk.sv
// Module: assertion checker bound to hw_ctrl_decoder. It watches the ports only.
module hw_ctrl_decoder_chk
    import hwc_pkg::*;
#(
    parameter int FETCH_SLOT = 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [INSTR_W-1:0] mem_word,
    input logic               ir_load,
    input logic               sc_clr,
    input logic               sc_load,
    input logic               sc_inc,
    input logic [NUM_T-1:0]   t_lines,
    input logic [NUM_OPS-1:0] d_lines,
    input logic               ind_flag,
    input logic [ADDR_W-1:0]  addr_bits,
    input logic               reg_ref,
    input logic               io_ref,
    input logic               ind_step
);
    assert_t_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(t_lines) == 1);
    assert_d_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(d_lines) == 1);
    assert_clr_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sc_clr |=> t_lines[0]);
    assert_inc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_inc && !sc_clr && !sc_load && !t_lines[NUM_T-1]) |=> t_lines == ($past(t_lines) << 1));
    assert_inc_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_inc && !sc_clr && !sc_load && t_lines[NUM_T-1]) |=> t_lines[0]);
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sc_inc && !sc_clr && !sc_load) |=> $stable(t_lines));
    assert_ir_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ir_load && t_lines[FETCH_SLOT]) |=> ($stable(addr_bits) && $stable(d_lines) && $stable(ind_flag)));
    assert_ind_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_load && t_lines[FETCH_SLOT]) |=> ind_flag == $past(mem_word[INSTR_W-1]));
    assert_class_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_ref, io_ref, ind_step}));
endmodule

bind hw_ctrl_decoder hw_ctrl_decoder_chk #(.FETCH_SLOT(FETCH_SLOT)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_word(mem_word), .ir_load(ir_load),
    .sc_clr(sc_clr), .sc_load(sc_load), .sc_inc(sc_inc), .t_lines(t_lines),
    .d_lines(d_lines), .ind_flag(ind_flag), .addr_bits(addr_bits),
    .reg_ref(reg_ref), .io_ref(io_ref), .ind_step(ind_step)
);

// File: tb/hw_ctrl_decoder_test.sv
// Bench: a driver task applies inputs, updates a reference model and queues the expected
// outputs. A monitor compares them at the next falling edge.
module hw_ctrl_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_word = '0;
    logic        ir_load = 1'b0, sc_clr = 1'b0, sc_load = 1'b0, sc_inc = 1'b0;
    logic [3:0]  sc_load_val = '0;
    logic [15:0] t_lines;
    logic [7:0]  d_lines;
    logic        ind_flag, reg_ref, io_ref, ind_step;
    logic [11:0] addr_bits;

    typedef struct packed {
        logic [15:0] t; logic [7:0] d; logic i; logic [11:0] a;
        logic rr; logic io; logic ind;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_chk = 0, n_fail = 0;
    bit    done = 0;
    logic [3:0]  m_sc = '0;
    logic [15:0] m_ir = '0;
    logic        m_i = 1'b0;

    hw_ctrl_decoder uut (
        .clk(clk), .rst_n(rst_n), .mem_word(mem_word), .ir_load(ir_load),
        .sc_clr(sc_clr), .sc_load(sc_load), .sc_load_val(sc_load_val), .sc_inc(sc_inc),
        .t_lines(t_lines), .d_lines(d_lines), .ind_flag(ind_flag), .addr_bits(addr_bits),
        .reg_ref(reg_ref), .io_ref(io_ref), .ind_step(ind_step)
    );

    // 250 MHz clock.
    always #2 clk = ~clk;

    // Compare one field and count it.
    task automatic chk(string tag, string fld, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", tag, fld, act, exp);
        end
    endtask

    // Build the expected outputs from the reference model.
    function automatic exp_t model_out();
        exp_t e;
        e.t   = 16'h1 << m_sc;
        e.d   = 8'h1 << m_ir[14:12];
        e.i   = m_i;
        e.a   = m_ir[11:0];
        e.rr  = e.d[7] & ~m_i;
        e.io  = e.d[7] & m_i;
        e.ind = (m_sc == 4'd3) & m_i & ~e.d[7];
        return e;
    endfunction

    // Driver: apply one cycle of inputs, step the model, queue the expectation.
    task automatic step(string tag, logic ld_ir, logic [15:0] w, logic clr, logic ld,
                        logic [3:0] lv, logic inc);
        @(negedge clk);
        ir_load = ld_ir; mem_word = w; sc_clr = clr; sc_load = ld; sc_load_val = lv; sc_inc = inc;
        @(posedge clk);
        #1;
        if (ld_ir && m_sc == 4'd1) begin m_ir = w; m_i = w[15]; end
        if (clr) m_sc = '0;
        else if (ld) m_sc = lv;
        else if (inc) m_sc = m_sc + 4'd1;
        exp_q.push_back(model_out());
        tag_q.push_back(tag);
    endtask

    // Monitor: pop expected items and compare them away from the rising edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            string tg;
            e = exp_q.pop_front();
            tg = tag_q.pop_front();
            chk(tg, "t_lines", 32'(t_lines), 32'(e.t));
            chk(tg, "d_lines", 32'(d_lines), 32'(e.d));
            chk(tg, "ind_flag", 32'(ind_flag), 32'(e.i));
            chk(tg, "addr_bits", 32'(addr_bits), 32'(e.a));
            chk(tg, "reg_ref", 32'(reg_ref), 32'(e.rr));
            chk(tg, "io_ref", 32'(io_ref), 32'(e.io));
            chk(tg, "ind_step", 32'(ind_step), 32'(e.ind));
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        mem_word = 16'hFFFF; sc_load = 1'b1; sc_load_val = 4'd9;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state, even with a pending load on the inputs.
        chk("R1", "t_lines", 32'(t_lines), 32'h1);
        chk("R1", "d_lines", 32'(d_lines), 32'h1);
        chk("R1", "ind_flag", 32'(ind_flag), 32'h0);
        chk("R1", "addr_bits", 32'(addr_bits), 32'h0);
        sc_load = 1'b0; mem_word = '0; rst_n = 1'b1;
        // R2/R3: count through all steps and wrap.
        for (int k = 0; k < 17; k++) step("R3", 0, 16'h0, 0, 0, 4'd0, 1);
        // R6: hold.
        step("R6", 0, 16'h0, 0, 0, 4'd0, 0);
        step("R6", 0, 16'h0, 0, 0, 4'd0, 0);
        // R5: load alone, then load beats increment.
        step("R5", 0, 16'h0, 0, 1, 4'd9, 0);
        step("R5", 0, 16'h0, 0, 1, 4'd14, 1);
        step("R3", 0, 16'h0, 0, 0, 4'd0, 1);
        step("R3", 0, 16'h0, 0, 0, 4'd0, 1);
        // R4: clear beats load and increment.
        step("R4", 0, 16'h0, 1, 1, 4'd7, 1);
        // R7/R9/R11: capture in the fetch slot while advancing, then reach the indirect step.
        step("R7", 1, 16'h4555, 0, 0, 4'd0, 1);
        step("R9", 1, 16'hA123, 0, 0, 4'd0, 1);
        step("R7", 1, 16'h3FFF, 0, 0, 4'd0, 1);
        step("R11", 1, 16'h3FFF, 0, 0, 4'd0, 1);
        step("R11", 0, 16'h0, 0, 0, 4'd0, 1);
        // R7: load request in step 1 with the counter held still captures once.
        step("R7", 0, 16'h0, 0, 1, 4'd1, 0);
        step("R10", 1, 16'h7800, 0, 0, 4'd0, 0);
        step("R10", 0, 16'h0, 0, 1, 4'd3, 0);
        step("R10", 0, 16'h0, 0, 1, 4'd1, 0);
        step("R10", 1, 16'hF040, 0, 0, 4'd0, 1);
        step("R11", 0, 16'h0, 0, 0, 4'd0, 1);
        // R8: every opcode value, direct and indirect, visiting the indirect step.
        for (int op = 0; op < 8; op++) begin
            step("R8", 0, 16'h0, 0, 1, 4'd1, 0);
            step("R8", 1, {op[0], op[2:0], 12'(op * 291)}, 0, 0, 4'd0, 1);
            step("R11", 0, 16'h0, 0, 0, 4'd0, 1);
        end
        wait (exp_q.size() == 0);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule